// File: doc/BRIEF.md
# Smart-Card Character Transmitter with Error-Driven Retransmission

This block sends bytes, one character at a time, on the single bidirectional I/O line of a smart-card interface. The logic level equals the bit value and bits go least significant first. Each character is framed as a low start bit, eight data bits, an even parity bit and high stop bits. Every bit lasts a programmable number of card-clock cycles. Outside a transmission the block does not drive the line, so the line stays in receive mode.

During the first stop bit the block stops driving the line, so the receiving card can pull the line low to report a parity error. The block samples the line on the last cycle of that stop bit. If the line is high, the character is complete after the second stop bit, and a byte already waiting may start right away. If the line is low, the block adds a third stop bit as a guard and sends the same byte again. A retry limit caps how many times it repeats; when the limit is used up, the byte is dropped and a one-cycle failure pulse is given.

A producer offers bytes through a valid/ready handshake. The bit-period divisor and the retry limit are captured at the moment a byte is accepted. The block drives a separate output-enable and output-data pair toward an external open-drain or tri-state pad. It reads back the line as a synchronous input.

Top module: `sc_char_tx`

## Requirements
- R1: After reset, and whenever no character is in progress, `line_oe` is 0, `tx_ready` is 1 and `tx_fail` is 0.
- R2: A character drives `line_oe` = 1 for ten bit periods, in this order: a 0 start bit, then `tx_byte` bit 0 through bit 7, then a parity bit that makes the count of ones in data plus parity even.
- R3: Each bit keeps its value for exactly `bit_div` clock cycles, with a value of 0 treated as 1. The divisor is captured when the byte is accepted, so later changes do not affect a character already in flight.
- R4: During the first stop bit (bit period 10 after the start), `line_oe` is 0. `line_in` is sampled on the clock edge that ends that bit, and a low level there is taken as an error report.
- R5: With no error reported, the second stop bit is driven high (`line_oe` = 1, `line_out` = 1). `tx_ready` rises in the last cycle of that stop bit, so a byte already offered starts its start bit exactly 12 bit periods after the previous start.
- R6: With an error reported, the second stop bit is released (`line_oe` = 0) and a third stop bit is driven high. The same byte is then resent, with its start bit beginning 13 bit periods after the previous start.
- R7: `retry_limit` (captured at acceptance) is the number of resends allowed. An error on the final permitted attempt drops the byte: there is no resend, and `tx_fail` pulses high for one cycle when the third stop bit ends. A `retry_limit` of 0 drops the byte on its first error.
- R8: A byte is accepted on a rising edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` stays 0 from the cycle after acceptance until the last cycle of the character's final stop bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (card-clock domain) |
| rst | input | 1 | Synchronous active-high reset |
| bit_div | input | DIV_W | Bit period in clock cycles, 0 taken as 1 |
| retry_limit | input | RETRY_W | Maximum number of resends per byte |
| tx_byte | input | DATA_W | Byte offered for transmission |
| tx_valid | input | 1 | Producer has a byte on `tx_byte` |
| tx_ready | output | 1 | Block can accept a byte this cycle |
| line_in | input | 1 | Synchronous level of the shared I/O line |
| line_oe | output | 1 | Drive enable toward the line pad |
| line_out | output | 1 | Level driven while `line_oe` is 1 |
| tx_fail | output | 1 | One-cycle pulse when a byte is dropped after its retries |

## Verification
The bytes chosen cover odd and even numbers of ones, all-zeros and all-ones, so the parity bit takes both values and bit ordering errors show as wrong data. Single bytes are sent with idle gaps in between, while bursts keep `tx_valid` high; only the bursts can show whether the next start bit follows the stop bits at exactly 12 bit periods. A model of the card pulls the line low during the first stop bit for a chosen number of attempts. This separates three outcomes: recovery after some resends, a drop at a retry limit of two, and an immediate drop at a limit of zero. Divisors of 0, 3, 5, 8 and 9, with one divisor changed while a byte is in flight, test the bit timing at its boundaries and the capture of settings at acceptance.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;

  // Character sequencer states
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SEND  = 3'd1,
    ST_STOP1 = 3'd2,
    ST_STOP2 = 3'd3,
    ST_STOP3 = 3'd4
  } tx_state_e;

  // Number of framing bits around the data field (start + parity)
  localparam int FRAME_EXTRA = 2;

endpackage

// File: rtl/sc_tx_bit_timer.sv
module sc_tx_bit_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  output logic             tick,
  output logic             tick_next
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  // tick marks the final cycle of a bit period
  assign tick      = run && (cnt_q == period - ONE);
  // tick_next predicts that the following cycle is a final cycle
  assign tick_next = tick ? (period == ONE) : ((cnt_q + ONE) == (period - ONE));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  // R3: counter never reaches the period while a character runs
  a_r3_count_below_period: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q < period));

endmodule

// File: rtl/sc_tx_frame.sv
module sc_tx_frame #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              rewind,
  input  logic              advance,
  input  logic [DATA_W-1:0] data,
  output logic              next_bit,
  output logic              last
);

  import sc_tx_pkg::*;

  localparam int FRAME_W = DATA_W + FRAME_EXTRA;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] frame_w;
  logic [FRAME_W-1:0] saved_q;
  logic [FRAME_W-1:0] sh_q;
  logic [IDX_W-1:0]   idx_q;

  // parity on top, data in the middle, start bit at the bottom
  assign frame_w = {^data, data, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      saved_q <= '1;
      sh_q    <= '1;
      idx_q   <= '0;
    end else if (load) begin
      saved_q <= frame_w;
      sh_q    <= frame_w;
      idx_q   <= '0;
    end else if (rewind) begin
      sh_q    <= saved_q;
      idx_q   <= '0;
    end else if (advance) begin
      sh_q    <= {1'b1, sh_q[FRAME_W-1:1]};
      idx_q   <= idx_q + 1'b1;
    end
  end

  assign next_bit = sh_q[1];
  assign last     = (idx_q == LAST_IDX);

  // R2: the sequencer never steps past the parity bit
  a_r2_no_step_past_parity: assert property (@(posedge clk) disable iff (rst)
    advance |-> !last);

  // R2: bit index stays inside the frame
  a_r2_index_in_frame: assert property (@(posedge clk) disable iff (rst)
    idx_q <= LAST_IDX);

endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx #(
  parameter int DIV_W   = 16,
  parameter int RETRY_W = 3,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIV_W-1:0]   bit_div,
  input  logic [RETRY_W-1:0] retry_limit,
  input  logic [DATA_W-1:0]  tx_byte,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic               line_in,
  output logic               line_oe,
  output logic               line_out,
  output logic               tx_fail
);

  import sc_tx_pkg::*;

  localparam logic [DIV_W-1:0] DIV_ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  tx_state_e          state_q, nxt;
  logic [DIV_W-1:0]   div_q;
  logic [RETRY_W-1:0] maxr_q, retry_q, retry_d;
  logic               err_q, err_d, drop_q, drop_d;
  logic               ready_q, ready_d;
  logic               oe_q, oe_d, out_q, out_d;
  logic               fail_q, fail_d;
  logic               load, rewind, advance, finish;
  logic               tick, tick_next, next_bit, last;
  logic               accept;

  assign accept = tx_valid && ready_q;

  sc_tx_bit_timer #(.CNT_W(DIV_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .run       (state_q != ST_IDLE),
    .period    (div_q),
    .tick      (tick),
    .tick_next (tick_next)
  );

  sc_tx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .rewind   (rewind),
    .advance  (advance),
    .data     (tx_byte),
    .next_bit (next_bit),
    .last     (last)
  );

  always_comb begin
    nxt     = state_q;
    load    = 1'b0;
    rewind  = 1'b0;
    advance = 1'b0;
    finish  = 1'b0;
    oe_d    = oe_q;
    out_d   = out_q;
    fail_d  = 1'b0;
    err_d   = err_q;
    drop_d  = drop_q;
    retry_d = retry_q;
    case (state_q)
      ST_IDLE: finish = 1'b1;
      ST_SEND: begin
        if (tick) begin
          if (last) begin
            nxt   = ST_STOP1;
            oe_d  = 1'b0;
            out_d = 1'b1;
          end else begin
            advance = 1'b1;
            out_d   = next_bit;
          end
        end
      end
      ST_STOP1: begin
        if (tick) begin
          nxt    = ST_STOP2;
          err_d  = !line_in;
          drop_d = !line_in && (retry_q == maxr_q);
          oe_d   = line_in;
          out_d  = 1'b1;
        end
      end
      ST_STOP2: begin
        if (tick) begin
          if (err_q) begin
            nxt   = ST_STOP3;
            oe_d  = 1'b1;
            out_d = 1'b1;
          end else begin
            finish = 1'b1;
          end
        end
      end
      ST_STOP3: begin
        if (tick) begin
          if (drop_q) begin
            finish = 1'b1;
            fail_d = 1'b1;
          end else begin
            nxt     = ST_SEND;
            rewind  = 1'b1;
            retry_d = retry_q + 1'b1;
            oe_d    = 1'b1;
            out_d   = 1'b0;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
    if (finish) begin
      if (accept) begin
        nxt     = ST_SEND;
        load    = 1'b1;
        oe_d    = 1'b1;
        out_d   = 1'b0;
        retry_d = '0;
      end else begin
        nxt   = ST_IDLE;
        oe_d  = 1'b0;
        out_d = 1'b1;
      end
    end
    ready_d = (nxt == ST_IDLE) ||
              (tick_next && (((nxt == ST_STOP2) && !err_d) ||
                             ((nxt == ST_STOP3) && drop_d)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      div_q   <= DIV_ONE;
      maxr_q  <= '0;
      retry_q <= '0;
      err_q   <= 1'b0;
      drop_q  <= 1'b0;
      ready_q <= 1'b1;
      oe_q    <= 1'b0;
      out_q   <= 1'b1;
      fail_q  <= 1'b0;
    end else begin
      state_q <= nxt;
      retry_q <= retry_d;
      err_q   <= err_d;
      drop_q  <= drop_d;
      ready_q <= ready_d;
      oe_q    <= oe_d;
      out_q   <= out_d;
      fail_q  <= fail_d;
      if (load) begin
        div_q  <= (bit_div == '0) ? DIV_ONE : bit_div;
        maxr_q <= retry_limit;
      end
    end
  end

  assign tx_ready = ready_q;
  assign line_oe  = oe_q;
  assign line_out = out_q;
  assign tx_fail  = fail_q;

  // R1: idle means released line and ready
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> (!oe_q && ready_q));

  // R2: data bits are always actively driven
  a_r2_send_driven: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SEND) |-> oe_q);

  // R4: line released during the first stop bit
  a_r4_stop1_released: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STOP1) |-> !oe_q);

  // R6: guard stop bit is driven high
  a_r6_stop3_high: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STOP3) |-> (oe_q && out_q));

  // R7: failure indication lasts a single cycle
  a_r7_fail_single: assert property (@(posedge clk) disable iff (rst)
    fail_q |=> !fail_q);

  // R7: resend count never exceeds the captured limit
  a_r7_retry_bound: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |-> (retry_q <= maxr_q));

  // R8: no acceptance while bits or the first stop bit are in flight
  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_SEND) || (state_q == ST_STOP1)) |-> !ready_q);

endmodule

// File: tb/sc_char_tx_bench.sv
`timescale 1ns/1ps
module sc_char_tx_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [15:0] bit_div = 16'd8;
  logic [2:0] retry_limit = 3'd2;
  logic [7:0] tx_byte = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready, line_oe, line_out, tx_fail, line_in;
  logic       card_pull = 1'b0;

  always #2 clk = ~clk;

  // open-drain style line with pull-up; card may pull low
  assign line_in = line_oe ? line_out : ~card_pull;

  sc_char_tx u_sc_char_tx (
    .clk         (clk),
    .rst         (rst),
    .bit_div     (bit_div),
    .retry_limit (retry_limit),
    .tx_byte     (tx_byte),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .line_in     (line_in),
    .line_oe     (line_oe),
    .line_out    (line_out),
    .tx_fail     (tx_fail)
  );

  typedef struct {
    logic [7:0] b;
    int         nerr;
    int         div;
    int         maxr;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  int attempt = 0;
  int exp_drops = 0;
  int fail_seen = 0;
  bit burst_mode = 1'b0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // driver: pushes the expectation, then completes the handshake
  task automatic send(input logic [7:0] b, input int nerr);
    item_t it;
    it.b    = b;
    it.nerr = nerr;
    it.div  = (bit_div == 0) ? 1 : int'(bit_div);
    it.maxr = int'(retry_limit);
    sb.push_back(it);
    tx_byte  = b;
    tx_valid = 1'b1;
    while (tx_ready !== 1'b1) @(negedge clk);
    @(negedge clk);
    check(tx_ready === 1'b0, "R8", int'(tx_ready), 0);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor plus card model: follows one character from its start bit
  task automatic run_char();
    item_t it;
    int d;
    bit inject, drop;
    logic [9:0] bits;
    logic [7:0] got;
    if (sb.size() == 0) begin
      check(1'b0, "R1", 1, 0);
      @(negedge clk);
      return;
    end
    it = sb[0];
    d = it.div;
    inject = (attempt < it.nerr);
    drop = inject && (attempt == it.maxr);
    bits = '0;
    for (int t = 0; t < (inject ? 13 : 12) * d; t++) begin
      for (int j = 0; j < 10; j++) begin
        if (t == j * d) begin
          bits[j] = line_out;
          check(line_oe === 1'b1, "R2", int'(line_oe), 1);
        end
        if (t == j * d + d - 1)
          check(line_oe === 1'b1 && line_out === bits[j], "R3", int'(line_out), int'(bits[j]));
      end
      if (t == 10 * d + d / 2) begin
        check(line_oe === 1'b0, "R4", int'(line_oe), 0);
        if (inject) card_pull = 1'b1;
      end
      if (t == 11 * d + d / 2) begin
        if (inject) check(line_oe === 1'b0, "R6", int'(line_oe), 0);
        else check(line_oe === 1'b1 && line_out === 1'b1, "R5", int'({line_oe, line_out}), 3);
        card_pull = 1'b0;
      end
      if (inject && t == 12 * d + d / 2)
        check(line_oe === 1'b1 && line_out === 1'b1, "R6", int'({line_oe, line_out}), 3);
      @(negedge clk);
    end
    got = bits[8:1];
    check(bits[0] === 1'b0, "R2", int'(bits[0]), 0);
    check(got === it.b, "R2", int'(got), int'(it.b));
    check(bits[9] === ^it.b, "R2", int'(bits[9]), int'(^it.b));
    if (inject) begin
      if (drop) begin
        check(tx_fail === 1'b1, "R7", int'(tx_fail), 1);
        if (sb.size() == 1) check(line_oe === 1'b0, "R7", int'(line_oe), 0);
        exp_drops++;
        void'(sb.pop_front());
        attempt = 0;
      end else begin
        check(line_oe === 1'b1 && line_out === 1'b0, "R6", int'({line_oe, line_out}), 2);
        attempt++;
      end
    end else begin
      void'(sb.pop_front());
      attempt = 0;
      if (burst_mode && sb.size() > 0)
        check(line_oe === 1'b1 && line_out === 1'b0, "R5", int'({line_oe, line_out}), 2);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (!rst && line_oe === 1'b1 && line_out === 1'b0) run_char();
    end
  end

  always @(negedge clk) begin
    if (!rst && tx_fail === 1'b1) fail_seen++;
    if (line_oe === 1'b1 && card_pull) begin
      checks++;
      errors++;
      $display("FAIL R4: actual line driven during card pull, expected released");
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(line_oe === 1'b0, "R1", int'(line_oe), 0);
    check(tx_ready === 1'b1, "R1", int'(tx_ready), 1);
    check(tx_fail === 1'b0, "R1", int'(tx_fail), 0);

    // single bytes, divisor 8
    send(8'hA5, 0); tx_valid = 1'b0; drain();
    send(8'h01, 0); tx_valid = 1'b0; drain();
    send(8'hFF, 0); tx_valid = 1'b0; drain();
    send(8'h00, 0); tx_valid = 1'b0; drain();
    check(line_oe === 1'b0 && tx_ready === 1'b1, "R1", int'({line_oe, tx_ready}), 1);

    // back-to-back burst (R5 chaining), one error inside
    burst_mode = 1'b1;
    send(8'h5A, 0);
    send(8'hC3, 0);
    send(8'h7E, 1);
    send(8'h18, 0);
    tx_valid = 1'b0;
    drain();
    burst_mode = 1'b0;

    // retries and drop with limit 2
    send(8'h3C, 1); tx_valid = 1'b0; drain();
    send(8'h81, 3); tx_valid = 1'b0; drain();
    send(8'h42, 2); tx_valid = 1'b0; drain();

    // R7 limit zero
    retry_limit = 3'd0;
    send(8'h99, 1); tx_valid = 1'b0; drain();
    retry_limit = 3'd2;

    // R3 capture: change divisor while a byte is in flight
    bit_div = 16'd5;
    send(8'h6D, 0);
    tx_valid = 1'b0;
    bit_div = 16'd9;
    drain();
    send(8'h12, 1); tx_valid = 1'b0; drain();

    // R3 divisor zero treated as one
    bit_div = 16'd0;
    send(8'hE7, 1); tx_valid = 1'b0; drain();
    send(8'h3C, 0); tx_valid = 1'b0; drain();

    // odd divisor with two resends
    bit_div = 16'd3;
    send(8'hB4, 2); tx_valid = 1'b0; drain();

    // R7 failure pulse count
    check(fail_seen == exp_drops, "R7", fail_seen, exp_drops);
    check(line_oe === 1'b0 && tx_ready === 1'b1 && tx_fail === 1'b0, "R1",
          int'({line_oe, tx_ready, tx_fail}), 2);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule